// File: doc/BRIEF.md
# Sync Edge Monitor and Line Counter

This block watches two sync lines, a vertical sync and a horizontal sync, on the master input clock. It detects the falling edge of each line by comparing the current sample with the sample one clock earlier. A falling edge on either line produces a one-cycle update strobe. A register bank elsewhere uses this strobe as the moment when staged settings may take effect.

Each horizontal falling edge starts a fixed reset delay. When the delay runs out, the horizontal pixel counter returns to zero. Between resets the counter climbs by one per clock and stops at its maximum value. If a new horizontal edge arrives while a delay is still pending, the delay starts again from the newer edge.

The block also enforces a placement rule for the two edges. A horizontal edge may fall in the same clock as a vertical edge, or at any time after it. A horizontal edge that falls one to five clocks ahead of a vertical edge breaks the rule. Such a violation sets a sticky flag, and software clears the flag with a clear strobe.

Top module: `sync_line_monitor`

## Requirements
- R1: While reset is held, and in the first cycle after its release, hCount is 0 and hCountRst, updStrobe and violFlag are all 0.
- R2: A horizontal falling edge means hdIn was sampled 1 at one rising clock edge and 0 at the next; call that next edge E. At edge E+RST_DLY (default 12), hCount becomes 0 and hCountRst rises for exactly one cycle. hCountRst stays 0 at all other times.
- R3: In every cycle without a counter reset, hCount rises by 1, and it holds at 2^CNT_W-1 instead of wrapping.
- R4: A new horizontal falling edge during a pending delay cancels the older delay. Only one reset follows, RST_DLY edges after the newest falling edge.
- R5: updStrobe is 1 for the one cycle after each edge that samples a falling edge on vdIn or hdIn. Rising edges and steady levels leave it at 0.
- R6: If a vertical falling edge is sampled 1 to 5 edges (VIOL_MIN..VIOL_MAX) after a horizontal falling edge, violFlag is set at that same edge.
- R7: No violation is flagged when the horizontal edge falls in the same clock as the vertical edge, after it, or 6 or more clocks before it.
- R8: violFlag stays set until violClr is sampled high, which clears it at the next edge. If a violation and violClr occur in the same cycle, the flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master input clock |
| rstN | input | 1 | Active-low synchronous reset |
| vdIn | input | 1 | Vertical sync level, already synchronous to clk |
| hdIn | input | 1 | Horizontal sync level, already synchronous to clk |
| violClr | input | 1 | Clear strobe for the sticky violation flag |
| hCount | output | CNT_W | Horizontal pixel counter |
| hCountRst | output | 1 | One-cycle strobe, high in the cycle the counter reads zero after a reset |
| updStrobe | output | 1 | One-cycle strobe that allows register updates after a sync falling edge |
| violFlag | output | 1 | Sticky flag for a horizontal edge placed too close before a vertical edge |

## Verification
The bench builds the block with CNT_W at 6, so the counter reaches its saturation value within about eighty clocks and the hold at the maximum can be observed directly. RST_DLY keeps its default of 12, and the violation window keeps its default of 1 to 5. This lets the bench probe the exact reset cycle, the cycle before it and the cycle after it. It also places horizontal-to-vertical spacings of 0, 1, 5 and 6 clocks on both borders of the window. A restart case moves a second horizontal edge into a pending delay, so the bench can check that the older reset never appears.

// File: rtl/slm_pkg.sv
package slm_pkg;
  // Strobes passed from control to datapath, one cycle wide each
  typedef struct packed {
    logic cntRst;    // counter returns to zero at the coming edge
    logic updPulse;  // a sync falling edge was seen this cycle
    logic violSet;   // placement rule broken this cycle
  } slmStrobe_t;
endpackage

// File: rtl/slm_edge.sv
module slm_edge #(
  parameter int LINES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] lineIn,
  output logic [LINES-1:0] fallDet
);
  logic [LINES-1:0] linePrev;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    // previous sample resets low so a line held low at reset gives no edge
    always_ff @(posedge clk) begin
      if (!rstN) linePrev[g] <= 1'b0;
      else       linePrev[g] <= lineIn[g];
    end
    assign fallDet[g] = linePrev[g] & ~lineIn[g];
  end
endmodule

// File: rtl/slm_ctrl.sv
module slm_ctrl
  import slm_pkg::*;
#(
  parameter int RST_DLY  = 12,
  parameter int VIOL_MIN = 1,
  parameter int VIOL_MAX = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       vdIn,
  input  logic       hdIn,
  output slmStrobe_t strb
);
  localparam int DLY_W   = (RST_DLY > 2) ? $clog2(RST_DLY) : 1;
  localparam int SINCE_W = $clog2(VIOL_MAX + 2);
  localparam logic [SINCE_W-1:0] SINCE_MAX = '1;
  localparam logic [SINCE_W-1:0] WIN_LO    = SINCE_W'(VIOL_MIN);
  localparam logic [SINCE_W-1:0] WIN_HI    = SINCE_W'(VIOL_MAX);
  localparam logic [DLY_W-1:0]   DLY_LOAD  = DLY_W'(RST_DLY - 1);

  logic [1:0] fall;
  logic       hdFall, vdFall;

  slm_edge #(.LINES(2)) u_edge (
    .clk    (clk),
    .rstN   (rstN),
    .lineIn ({vdIn, hdIn}),
    .fallDet(fall)
  );

  assign hdFall = fall[0];
  assign vdFall = fall[1];

  // reset delay: loaded on every horizontal fall, counts down to zero
  logic             pending;
  logic [DLY_W-1:0] dlyCnt;
  logic             dlyDone;

  assign dlyDone = pending && (dlyCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
      dlyCnt  <= '0;
    end else if (hdFall) begin
      pending <= 1'b1;
      dlyCnt  <= DLY_LOAD;
    end else if (pending) begin
      if (dlyCnt == '0) pending <= 1'b0;
      else              dlyCnt  <= dlyCnt - 1'b1;
    end
  end

  // clocks since the last horizontal fall, saturating; starts saturated
  logic [SINCE_W-1:0] sinceHd;

  always_ff @(posedge clk) begin
    if (!rstN)                  sinceHd <= SINCE_MAX;
    else if (hdFall)            sinceHd <= SINCE_W'(1);
    else if (sinceHd != SINCE_MAX) sinceHd <= sinceHd + 1'b1;
  end

  logic inWindow;
  assign inWindow = (sinceHd >= WIN_LO) && (sinceHd <= WIN_HI);

  always_comb begin
    strb          = '0;
    strb.cntRst   = dlyDone && !hdFall;   // a fresh edge restarts the delay
    strb.updPulse = vdFall || hdFall;
    strb.violSet  = vdFall && inWindow;
  end
endmodule

// File: rtl/slm_dpath.sv
module slm_dpath
  import slm_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  slmStrobe_t       strb,
  input  logic             violClr,
  output logic [CNT_W-1:0] hCount,
  output logic             hCountRst,
  output logic             updStrobe,
  output logic             violFlag
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rstN)                 hCount <= '0;
    else if (strb.cntRst)      hCount <= '0;
    else if (hCount != CNT_MAX) hCount <= hCount + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hCountRst <= 1'b0;
      updStrobe <= 1'b0;
    end else begin
      hCountRst <= strb.cntRst;
      updStrobe <= strb.updPulse;
    end
  end

  // a set in the same cycle as a clear wins
  always_ff @(posedge clk) begin
    if (!rstN)             violFlag <= 1'b0;
    else if (strb.violSet) violFlag <= 1'b1;
    else if (violClr)      violFlag <= 1'b0;
  end
endmodule

// File: rtl/sync_line_monitor.sv
module sync_line_monitor
  import slm_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int RST_DLY  = 12,
  parameter int VIOL_MIN = 1,
  parameter int VIOL_MAX = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             vdIn,
  input  logic             hdIn,
  input  logic             violClr,
  output logic [CNT_W-1:0] hCount,
  output logic             hCountRst,
  output logic             updStrobe,
  output logic             violFlag
);
  slmStrobe_t strb;

  slm_ctrl #(
    .RST_DLY (RST_DLY),
    .VIOL_MIN(VIOL_MIN),
    .VIOL_MAX(VIOL_MAX)
  ) u_ctrl (
    .clk (clk),
    .rstN(rstN),
    .vdIn(vdIn),
    .hdIn(hdIn),
    .strb(strb)
  );

  slm_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .violClr  (violClr),
    .hCount   (hCount),
    .hCountRst(hCountRst),
    .updStrobe(updStrobe),
    .violFlag (violFlag)
  );
endmodule

// File: rtl/slm_chk.sv
module slm_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             vdIn,
  input logic             hdIn,
  input logic             violClr,
  input logic [CNT_W-1:0] hCount,
  input logic             hCountRst,
  input logic             updStrobe,
  input logic             violFlag
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R2
  rst_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    hCountRst |=> !hCountRst);

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (hCountRst ||
              (hCount == CNT_W'($past(hCount) + 1'b1)) ||
              (hCount == CNT_MAX && $past(hCount) == CNT_MAX)));

  // R5
  upd_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    updStrobe |-> (($past(vdIn, 2) && !$past(vdIn)) ||
                   ($past(hdIn, 2) && !$past(hdIn))));

  // R6
  viol_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(violFlag) |-> ($past(vdIn, 2) && !$past(vdIn)));

  // R8
  viol_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(violFlag) |-> $past(violClr));
endmodule

bind sync_line_monitor slm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .vdIn     (vdIn),
  .hdIn     (hdIn),
  .violClr  (violClr),
  .hCount   (hCount),
  .hCountRst(hCountRst),
  .updStrobe(updStrobe),
  .violFlag (violFlag)
);

// File: tb/sync_line_monitor_tb_top.sv
module sync_line_monitor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 6;
  localparam int CMAX       = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rstN, vdIn, hdIn, violClr;
  logic [CNT_W-1:0] hCount;
  logic hCountRst, updStrobe, violFlag;
  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_line_monitor #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .vdIn(vdIn), .hdIn(hdIn), .violClr(violClr),
    .hCount(hCount), .hCountRst(hCountRst), .updStrobe(updStrobe),
    .violFlag(violFlag)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    vdIn = 1'b1; hdIn = 1'b1; violClr = 1'b0;
    step(20);
  endtask

  task automatic tReset();
    rstN = 1'b0; vdIn = 1'b1; hdIn = 1'b1; violClr = 1'b0;
    step(3);
    chk("R1 hCount", hCount, 0);
    chk("R1 hCountRst", hCountRst, 0);
    chk("R1 updStrobe", updStrobe, 0);
    chk("R1 violFlag", violFlag, 0);
    rstN = 1'b1;
    step(1);
    chk("R1 hCount after release", hCount, 1);
    chk("R1 updStrobe after release", updStrobe, 0);
  endtask

  task automatic tHdReset();
    idle();
    hdIn = 1'b0;
    step(12);
    chk("R2 no strobe one cycle early", hCountRst, 0);
    step(1);
    chk("R2 hCount zero", hCount, 0);
    chk("R2 strobe high", hCountRst, 1);
    step(1);
    chk("R2 strobe one cycle", hCountRst, 0);
    chk("R3 count after reset", hCount, 1);
    step(5);
    chk("R3 count climbs", hCount, 6);
    hdIn = 1'b1;
    step(1);
    chk("R2 rising edge no reset", hCountRst, 0);
  endtask

  task automatic tSaturate();
    idle();
    hdIn = 1'b0;
    step(13);
    chk("R3 start zero", hCount, 0);
    step(CMAX);
    chk("R3 reaches max", hCount, CMAX);
    step(10);
    chk("R3 holds max", hCount, CMAX);
    chk("R3 no wrap strobe", hCountRst, 0);
  endtask

  task automatic tRestart();
    idle();
    hdIn = 1'b0;
    step(3);
    hdIn = 1'b1;
    step(2);
    hdIn = 1'b0;
    step(8);
    chk("R4 old delay cancelled strobe", hCountRst, 0);
    chk("R4 old delay cancelled count", hCount, CMAX);
    step(5);
    chk("R4 reset after newest edge", hCount, 0);
    chk("R4 strobe after newest edge", hCountRst, 1);
  endtask

  task automatic tUpdate();
    idle();
    vdIn = 1'b0;
    step(1);
    chk("R5 vd fall strobe", updStrobe, 1);
    step(1);
    chk("R5 strobe one cycle", updStrobe, 0);
    vdIn = 1'b1;
    step(1);
    chk("R5 vd rise no strobe", updStrobe, 0);
    step(3);
    hdIn = 1'b0;
    step(1);
    chk("R5 hd fall strobe", updStrobe, 1);
    hdIn = 1'b1;
    step(1);
    chk("R5 hd rise no strobe", updStrobe, 0);
    chk("R7 distant edges no violation", violFlag, 0);
  endtask

  // horizontal falls d clocks before vertical
  task automatic tSpacing(int d, int expViol, string req);
    idle();
    violClr = 1'b1;
    step(1);
    violClr = 1'b0;
    hdIn = 1'b0;
    if (d > 0) step(d);
    vdIn = 1'b0;
    step(1);
    chk(req, violFlag, expViol);
  endtask

  task automatic tVdFirst();
    idle();
    vdIn = 1'b0;
    step(2);
    hdIn = 1'b0;
    step(1);
    chk("R7 hd after vd", violFlag, 0);
    step(5);
    chk("R7 hd after vd later", violFlag, 0);
  endtask

  task automatic tClear();
    tSpacing(3, 1, "R6 spacing 3");
    step(3);
    chk("R8 flag sticky", violFlag, 1);
    violClr = 1'b1;
    step(1);
    violClr = 1'b0;
    chk("R8 clear", violFlag, 0);
    idle();
    hdIn = 1'b0;
    step(2);
    vdIn = 1'b0;
    violClr = 1'b1;
    step(1);
    violClr = 1'b0;
    chk("R8 set wins over clear", violFlag, 1);
  endtask

  initial begin
    tReset();
    tHdReset();
    tSaturate();
    tRestart();
    tUpdate();
    tSpacing(0, 0, "R7 same cycle");
    tSpacing(1, 1, "R6 spacing 1");
    tSpacing(5, 1, "R6 spacing 5");
    tSpacing(6, 0, "R7 spacing 6");
    tVdFirst();
    tClear();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule